// File: doc/BRIEF.md
# Burst DRAM Access Sequencer

This block sits between a processor bus and a bank of page-mode DRAM and serves four-beat line burst reads. It samples a single-cycle transfer-start strobe and then drives the row strobe, the column strobe, a row/column address select, the two low column address bits and one transfer acknowledge per beat back to the processor. All strobe outputs are active high: 1 means asserted. Any inversion to the DRAM pin polarity is left to the board.

Beat timing is fixed at elaboration. The package turns nanosecond figures into clock counts. The first beat takes one clock for the start strobe plus the ceiling of (row strobe delay + row access + input setup) / clock period. Each later beat takes that same ceiling computed with the column figures, plus one clock during which the column strobe stays negated. With the default figures the pattern is 5:3:3:3. A start that follows a burst too closely gets extra leading clocks so the row strobe can precharge, which gives 7:3:3:3. A start that arrives while a burst is running is held and is served when that burst ends.

Top module: `dram_burst_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, all outputs are 0 (row strobe, column strobe, select, column bits, acknowledge).
- R2: With no precharge penalty, a start sampled in cycle s gives the first acknowledge in cycle s+4, so the first beat spans 5 clocks counting the start cycle.
- R3: Each burst gives exactly four acknowledges, each one cycle wide. The second, third and fourth come 3 cycles after the previous one.
- R4: The row strobe is asserted from cycle s+1 (no penalty) through the cycle of the fourth acknowledge, and negated in the cycle after it.
- R5: The column strobe is asserted in the acknowledge cycle of each beat and in the cycle before it, and negated at all other times. This leaves one negated cycle between beats.
- R6: The address select is 0 (row) while idle and while the row strobe asserts. It is 1 (column) from two cycles before the first acknowledge through the end of the burst, which is one cycle before the first column strobe.
- R7: The column bits show the beat number 0, 1, 2, 3 for the beat in progress. They are 0 when idle.
- R8: When a start is taken in the first or second cycle after the fourth acknowledge of the previous burst, 2 clocks are added to the first beat (7:3:3:3), and the row strobe asserts 2 cycles later. A start taken three or more cycles after that acknowledge gets no penalty.
- R9: A start sampled while a burst is running, including in its last acknowledge cycle, is held. The held burst begins in the cycle after the fourth acknowledge of the current burst and gets the penalty of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_start | input | 1 | Transfer-start strobe, one cycle per burst request |
| row_strobe | output | 1 | DRAM row strobe, 1 = asserted |
| col_strobe | output | 1 | DRAM column strobe, 1 = asserted |
| addr_col_sel | output | 1 | Address mux select: 0 = row, 1 = column |
| col_low | output | 2 | Low column address bits, the beat index |
| xfer_ack | output | 1 | Transfer acknowledge, one cycle per beat |

## Verification
The assertions rely on the bus issuing at most one start request per running burst. A second request inside the same burst would merge with the held one, and the held-request check does not cover that case. The random stimulus enforces this: it draws a start with fixed odds only when the bench's own model holds no pending request. The directed cases place starts at one, two and three cycles after a final acknowledge, and in the middle of a burst, to cover the edges of the precharge window.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int BEATS = 4;

    typedef logic [1:0] beat_t;
    localparam beat_t LAST_BEAT = beat_t'(BEATS - 1);

    typedef struct packed {
        logic  ras;
        logic  cas;
        logic  col_sel;
        beat_t col_low;
        logic  ack;
    } dram_ctl_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // clocks from start cycle to first acknowledge, inclusive
    function automatic int first_beat_clks(input int prop_ns, input int acc_ns,
                                           input int setup_ns, input int clk_ns);
        return 1 + ceil_div(prop_ns + acc_ns + setup_ns, clk_ns);
    endfunction

    // clocks between consecutive acknowledges, one of them for strobe precharge
    function automatic int later_beat_clks(input int prop_ns, input int acc_ns,
                                           input int setup_ns, input int clk_ns);
        return ceil_div(prop_ns + acc_ns + setup_ns, clk_ns) + 1;
    endfunction

endpackage

// File: rtl/dbs_start_gate.sv
module dbs_start_gate #(
    parameter int PRE_GAP = 2,
    parameter int IDLE_W  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic xfer_start,
    input  logic busy,
    input  logic last_ack,
    output logic start,
    output logic pen_apply
);
    localparam logic [IDLE_W-1:0] GAP_V = IDLE_W'(PRE_GAP);

    logic              pend;
    logic [IDLE_W-1:0] idle_cnt;

    assign start     = !busy && (xfer_start || pend);
    assign pen_apply = idle_cnt < GAP_V;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (start) begin
            pend <= 1'b0;
        end else if (xfer_start) begin
            pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= GAP_V;
        end else if (last_ack) begin
            idle_cnt <= '0;
        end else if (!busy && idle_cnt < GAP_V) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_start && busy) |=> pend);

    // R8
    idle_restart_chk: assert property (@(posedge clk) disable iff (rst)
        last_ack |=> (idle_cnt == '0));

endmodule

// File: rtl/dbs_burst_timer.sv
module dbs_burst_timer
    import dbs_pkg::*;
#(
    parameter int FIRST_CLKS = 5,
    parameter int LATER_CLKS = 3,
    parameter int PENALTY    = 2,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             pen_apply,
    output logic             busy,
    output beat_t            beat,
    output logic [CNT_W-1:0] cnt,
    output logic             last_ack
);
    localparam logic [CNT_W-1:0] LOAD_PLAIN = CNT_W'(FIRST_CLKS - 2);
    localparam logic [CNT_W-1:0] LOAD_PEN   = CNT_W'(FIRST_CLKS - 2 + PENALTY);
    localparam logic [CNT_W-1:0] LOAD_NEXT  = CNT_W'(LATER_CLKS - 1);

    logic beat_end;

    assign beat_end = busy && (cnt == '0);
    assign last_ack = beat_end && (beat == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            beat <= '0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            beat <= '0;
            cnt  <= pen_apply ? LOAD_PEN : LOAD_PLAIN;
        end else if (beat_end) begin
            if (beat == LAST_BEAT) begin
                busy <= 1'b0;
                beat <= '0;
                cnt  <= '0;
            end else begin
                beat <= beat + 1'b1;
                cnt  <= LOAD_NEXT;
            end
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R9
    start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R3
    four_beats_chk: assert property (@(posedge clk) disable iff (rst)
        last_ack |=> !busy);

endmodule

// File: rtl/dbs_strobe_decode.sv
module dbs_strobe_decode
    import dbs_pkg::*;
#(
    parameter int FIRST_CLKS = 5,
    parameter int LATER_CLKS = 3,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  beat_t            beat,
    input  logic [CNT_W-1:0] cnt,
    output dram_ctl_t        ctl
);
    localparam logic [CNT_W-1:0] ROW_LAST = CNT_W'(FIRST_CLKS - 2);
    localparam logic [CNT_W-1:0] COL_FROM = CNT_W'(LATER_CLKS - 1);
    localparam logic [CNT_W-1:0] CAS_FROM = CNT_W'(LATER_CLKS - 2);

    logic first_beat;

    assign first_beat = (beat == '0);

    always_comb begin
        ctl.ras     = busy && !(first_beat && cnt > ROW_LAST);
        ctl.cas     = busy && (cnt <= CAS_FROM);
        ctl.col_sel = busy && (!first_beat || cnt <= COL_FROM);
        ctl.col_low = busy ? beat : '0;
        ctl.ack     = busy && (cnt == '0);
    end

    // R5
    cas_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.ack && beat != LAST_BEAT) |=> !ctl.cas);

    // R6
    col_before_cas_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctl.cas) && first_beat) |-> $past(ctl.col_sel));

    // R3
    ack_width_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.ack |=> !ctl.ack);

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
    import dbs_pkg::*;
#(
    parameter int CLK_NS      = 20,
    parameter int RAS_PROP_NS = 5,
    parameter int RAS_ACC_NS  = 65,
    parameter int CAS_PROP_NS = 5,
    parameter int CAS_ACC_NS  = 20,
    parameter int SETUP_NS    = 7,
    parameter int PRE_GAP     = 2,
    parameter int PENALTY     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_start,
    output logic       row_strobe,
    output logic       col_strobe,
    output logic       addr_col_sel,
    output logic [1:0] col_low,
    output logic       xfer_ack
);
    localparam int FIRST_CLKS = first_beat_clks(RAS_PROP_NS, RAS_ACC_NS, SETUP_NS, CLK_NS);
    localparam int LATER_CLKS = later_beat_clks(CAS_PROP_NS, CAS_ACC_NS, SETUP_NS, CLK_NS);
    localparam int CNT_W      = $clog2(FIRST_CLKS + PENALTY + 1);
    localparam int IDLE_W     = $clog2(PRE_GAP + 1) + 1;

    logic             start;
    logic             pen_apply;
    logic             busy;
    logic             last_ack;
    beat_t            beat;
    logic [CNT_W-1:0] cnt;
    dram_ctl_t        ctl;

    dbs_start_gate #(.PRE_GAP(PRE_GAP), .IDLE_W(IDLE_W)) gate_i (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .busy(busy),
        .last_ack(last_ack), .start(start), .pen_apply(pen_apply)
    );

    dbs_burst_timer #(.FIRST_CLKS(FIRST_CLKS), .LATER_CLKS(LATER_CLKS),
                      .PENALTY(PENALTY), .CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .start(start), .pen_apply(pen_apply),
        .busy(busy), .beat(beat), .cnt(cnt), .last_ack(last_ack)
    );

    dbs_strobe_decode #(.FIRST_CLKS(FIRST_CLKS), .LATER_CLKS(LATER_CLKS),
                        .CNT_W(CNT_W)) decode_i (
        .clk(clk), .rst(rst), .busy(busy), .beat(beat), .cnt(cnt), .ctl(ctl)
    );

    assign row_strobe   = ctl.ras;
    assign col_strobe   = ctl.cas;
    assign addr_col_sel = ctl.col_sel;
    assign col_low      = ctl.col_low;
    assign xfer_ack     = ctl.ack;

    // R4
    ras_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(row_strobe) |-> $past(xfer_ack));

    // R2
    start_ras_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !pen_apply) |=> row_strobe);

    // R8
    pen_ras_chk: assert property (@(posedge clk) disable iff (rst)
        (start && pen_apply) |=> !row_strobe);

endmodule

// File: tb/dram_burst_seq_tb_top.sv
module dram_burst_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0;
    logic       row_strobe, col_strobe, addr_col_sel, xfer_ack;
    logic [1:0] col_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    int  cyc = 0;
    bit  mb = 0;
    bit  mpend = 0;
    bit  mpen = 0;
    int  mbeat = 0;
    int  mstart = 0;
    int  mnext = 0;
    int  mlast = -100;
    int  ack_log[16];
    int  ack_n = 0;

    always #10 clk = ~clk;

    dram_burst_seq dut_i (
        .clk(clk), .rst(rst), .xfer_start(xfer_start),
        .row_strobe(row_strobe), .col_strobe(col_strobe),
        .addr_col_sel(addr_col_sel), .col_low(col_low), .xfer_ack(xfer_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic int first_gap(input bit pen);
        return pen ? 7 : 5;
    endfunction

    function automatic bit pen_due(input int c, input int last);
        return (c - last - 1) < 2;
    endfunction

    task automatic compare();
        bit e_ack, e_ras, e_cas, e_col;
        int e_low;
        string rq;
        e_ack = mb && (cyc == mnext);
        e_ras = mb && (cyc >= mstart + 1 + (mpen ? 2 : 0));
        e_cas = mb && (cyc >= mnext - 1);
        e_col = mb && (mbeat > 0 || cyc >= mnext - 2);
        e_low = mb ? mbeat : 0;
        rq = (mbeat == 0) ? (mpen ? "R8" : "R2") : "R3";
        chk(xfer_ack == e_ack, rq, int'(xfer_ack), int'(e_ack));
        chk(row_strobe == e_ras, mpen ? "R8 row" : "R4", int'(row_strobe), int'(e_ras));
        chk(col_strobe == e_cas, "R5", int'(col_strobe), int'(e_cas));
        chk(addr_col_sel == e_col, "R6", int'(addr_col_sel), int'(e_col));
        chk(int'(col_low) == e_low, "R7", int'(col_low), e_low);
        if (xfer_ack && ack_n < 16) begin
            ack_log[ack_n] = cyc;
            ack_n++;
        end
    endtask

    task automatic model_update();
        bit was_busy;
        was_busy = mb;
        if (mb && cyc == mnext) begin
            if (mbeat == 3) begin
                mb = 0;
                mlast = cyc;
            end else begin
                mbeat++;
                mnext += 3;
            end
        end
        if (!was_busy && (xfer_start || mpend)) begin
            mpen   = pen_due(cyc, mlast);
            mstart = cyc;
            mnext  = cyc + first_gap(mpen) - 1;
            mb     = 1;
            mbeat  = 0;
            mpend  = 0;
        end else if (xfer_start) begin
            mpend = 1;
        end
    endtask

    task automatic step(input logic t);
        @(posedge clk);
        #1;
        cyc++;
        xfer_start = t;
        @(negedge clk);
        compare();
        model_update();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    initial begin
        int s0, s1;
        void'($urandom(32'd20240611));
        // R1: outputs during reset
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            @(negedge clk);
            chk({row_strobe, col_strobe, addr_col_sel, col_low, xfer_ack} == 6'b0,
                "R1", int'({row_strobe, col_strobe, addr_col_sel, col_low, xfer_ack}), 0);
        end
        rst = 1'b0;
        idle(4);

        // R2 R3: isolated burst, then R8 start one cycle after the fourth ack
        ack_n = 0;
        step(1'b1);
        s0 = cyc;
        idle(13);
        step(1'b1);
        s1 = cyc;
        idle(20);
        chk(ack_n == 8, "R3 ack count", ack_n, 8);
        chk(ack_log[0] - s0 + 1 == 5, "R2 first gap", ack_log[0] - s0 + 1, 5);
        chk(ack_log[4] - s1 + 1 == 7, "R8 first gap", ack_log[4] - s1 + 1, 7);
        for (int k = 1; k < 4; k++) begin
            chk(ack_log[k] - ack_log[k-1] == 3, "R3 gap", ack_log[k] - ack_log[k-1], 3);
            chk(ack_log[k+4] - ack_log[k+3] == 3, "R3 gap", ack_log[k+4] - ack_log[k+3], 3);
        end

        // R8: start two cycles after the fourth ack still pays the penalty
        ack_n = 0;
        step(1'b1);
        idle(14);
        step(1'b1);
        s1 = cyc;
        idle(20);
        chk(ack_log[4] - s1 + 1 == 7, "R8 two-cycle gap", ack_log[4] - s1 + 1, 7);

        // R8: three cycles after the fourth ack there is no penalty
        ack_n = 0;
        step(1'b1);
        idle(15);
        step(1'b1);
        s1 = cyc;
        idle(20);
        chk(ack_log[4] - s1 + 1 == 5, "R8 no-penalty gap", ack_log[4] - s1 + 1, 5);

        // R9: start pulsed mid-burst is held and served with penalty
        ack_n = 0;
        step(1'b1);
        s0 = cyc;
        idle(5);
        step(1'b1);
        idle(30);
        chk(ack_n == 8, "R9 held burst served", ack_n, 8);
        chk(ack_log[4] - ack_log[3] == 7, "R9 held first gap", ack_log[4] - ack_log[3], 7);

        // R9: start pulsed in the last ack cycle is held
        ack_n = 0;
        step(1'b1);
        idle(12);
        step(1'b1);
        idle(30);
        chk(ack_n == 8, "R9 held at last ack", ack_n, 8);

        // random mix, at most one pending request per burst
        for (int i = 0; i < 3000; i++) begin
            bit t;
            t = ($urandom % 6 == 0) && !mpend;
            step(t);
        end
        idle(40);
        chk(!mb && xfer_ack == 1'b0, "R3 drained", int'(xfer_ack), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule